// File: doc/BRIEF.md
# Clip and Thermal Warning Reporter

This block gathers clipping indications from four PWM output channels and a three-level die-temperature warning. It reports them on one shared active-low warning pin. A channel counts as clipping when its PWM stream stops toggling and stays high for longer than a full PWM period, which is what a 100% duty cycle looks like. The indication clears as soon as the stream drops low again.

A 2-bit mode input selects what drives the pin:
- the first warning level,
- the clip indication,
- the OR of the two,
- or a diagnostic tweeter-detection bit passed straight through.

The block also follows the temperature code against three hysteretic warning thresholds and a shutdown threshold. At the shutdown threshold it requests high impedance on all outputs and asserts the fault pin. It leaves that state only when the die has cooled and a restart command arrives. The status field and the warning pin keep working throughout the shutdown. While the outputs are off, clip tracking is held cleared.

Top module: `cwr_top`

## Requirements
- R1: Reset state: `warnPinN` is 1, `thermStatus` is 0, `outHiZ` is 0 and `faultN` is 1.
- R2: A channel counts as clipping once its PWM input has been sampled high on PWM_PERIOD+1 consecutive clock edges (17 with the default period of 16). A single low sample clears that channel's run count at that edge.
- R3: The clip indication is the OR over all four channels. `warnPinN` is registered and active low: the pin value after an edge reflects the clip and level state held before that edge.
- R4: `pinMode` encoding: 2'b00 routes warning level 1 only; 2'b01 routes the clip indication only; 2'b10 routes the OR of clip and warning level 1; 2'b11 routes `tweeterIn`. Code 00 is the cleared configuration, so a freshly reset configuration reports the thermal warning only.
- R5: `thermStatus` bit 0, 1 and 2 hold warning levels 1, 2 and 3 (defaults 100, 115 and 130 in temperature code units). A level sets at the edge where `tempCode` is at or above its threshold. It clears at the edge where `tempCode` plus 10 is below the threshold. Otherwise it holds.
- R6: At the edge where `tempCode` is at or above the shutdown threshold (default 150), the block enters shutdown: `outHiZ` goes to 1 and `faultN` goes to 0.
- R7: Shutdown is left only by a `restartReq` at an edge after `tempCode` has been seen below the shutdown threshold minus 10. A restart while still hot has no effect.
- R8: While `outHiZ` is 1, all clip run counts are held at zero, so the clip indication cannot drive the pin.
- R9: Warning levels keep tracking the temperature during shutdown, so the status field stays valid while the outputs are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 4 | PWM stream of each channel |
| tempCode | input | 8 | Die temperature code, one unit per degree |
| pinMode | input | 2 | Warning pin source select |
| tweeterIn | input | 1 | Tweeter-detection diagnostic bit |
| restartReq | input | 1 | Software restart command after thermal shutdown |
| warnPinN | output | 1 | Shared warning pin, active low |
| thermStatus | output | 3 | Warning levels 1 to 3 |
| outHiZ | output | 1 | Request to place all outputs in high impedance |
| faultN | output | 1 | Fault pin, active low |

## Verification
The properties assume that `pinMode`, `pwmIn`, `tweeterIn` and `tempCode` are synchronous to `clk` and change only between edges. They also assume the thresholds are ordered, with level 3 the highest and every threshold at least the hysteresis value. The bench changes all inputs at the falling edge. It keeps the default threshold ordering, and it drives the temperature as a bounded random walk with occasional jumps. That walk crosses every set and clear point, and in both directions. The PWM streams are biased toward long high runs so that clip runs both complete and break.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  typedef enum logic [1:0] {
    MODE_WARN  = 2'b00,
    MODE_CLIP  = 2'b01,
    MODE_BOTH  = 2'b10,
    MODE_TWEET = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_HOT    = 2'b01,
    ST_COOLED = 2'b10
  } shut_state_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic selClip;
    logic selWarn;
    logic selTweet;
    logic clipFlush;
  } ctrl_strobe_t;

  // temperature comparisons from the datapath into control
  typedef struct packed {
    logic atShut;
    logic coolShut;
  } temp_flags_t;

endpackage

// File: rtl/cwr_datapath.sv
module cwr_datapath
  import cwr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int PWM_PERIOD = 16,
  parameter int TEMP_W     = 8,
  parameter int WARN_T1    = 100,
  parameter int WARN_T2    = 115,
  parameter int WARN_T3    = 130,
  parameter int SHUT_T     = 150,
  parameter int HYST       = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pwmIn,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic              tweeterIn,
  input  ctrl_strobe_t      ctrl,
  output logic              warnPinN,
  output logic [2:0]        thermStatus,
  output temp_flags_t       tempFlags
);

  localparam int CLIP_CNT = PWM_PERIOD + 1;
  localparam int CNT_W    = $clog2(CLIP_CNT + 1);
  localparam int NUM_LVL  = 3;
  localparam int EXT_W    = TEMP_W + 1;
  localparam logic [TEMP_W-1:0] LVL_TH [NUM_LVL] =
    '{TEMP_W'(WARN_T1), TEMP_W'(WARN_T2), TEMP_W'(WARN_T3)};
  localparam logic [EXT_W-1:0] HYST_X = EXT_W'(HYST);

  logic [NUM_CH-1:0]  chanClip;
  logic [NUM_LVL-1:0] warnLvl;
  logic [EXT_W-1:0]   tempPlusHyst;
  logic               anyClip;

  assign tempPlusHyst = {1'b0, tempCode} + HYST_X;

  // per-channel run-length of high samples, saturating at the clip count
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [CNT_W-1:0] highRun;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        highRun <= '0;
      end else if (ctrl.clipFlush || !pwmIn[c]) begin
        highRun <= '0;
      end else if (highRun != CNT_W'(CLIP_CNT)) begin
        highRun <= highRun + 1'b1;
      end
    end
    assign chanClip[c] = (highRun == CNT_W'(CLIP_CNT));
  end

  assign anyClip = |chanClip;

  // hysteretic warning levels
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        warnLvl[i] <= 1'b0;
      end else if (tempCode >= LVL_TH[i]) begin
        warnLvl[i] <= 1'b1;
      end else if (tempPlusHyst < {1'b0, LVL_TH[i]}) begin
        warnLvl[i] <= 1'b0;
      end
    end
  end

  assign thermStatus = warnLvl;

  assign tempFlags.atShut   = (tempCode >= TEMP_W'(SHUT_T));
  assign tempFlags.coolShut = (tempPlusHyst < EXT_W'(SHUT_T));

  // shared active-low pin, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warnPinN <= 1'b1;
    end else begin
      warnPinN <= ~((ctrl.selClip  && anyClip)    ||
                    (ctrl.selWarn  && warnLvl[0]) ||
                    (ctrl.selTweet && tweeterIn));
    end
  end

endmodule

// File: rtl/cwr_control.sv
module cwr_control
  import cwr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   pinMode,
  input  logic         restartReq,
  input  temp_flags_t  tempFlags,
  output ctrl_strobe_t ctrl,
  output logic         outHiZ,
  output logic         faultN
);

  shut_state_e shutState, shutNext;
  pin_mode_e   modeSel;

  assign modeSel = pin_mode_e'(pinMode);

  always_comb begin
    shutNext = shutState;
    unique case (shutState)
      ST_RUN:    if (tempFlags.atShut) shutNext = ST_HOT;
      ST_HOT:    if (tempFlags.coolShut) shutNext = ST_COOLED;
      ST_COOLED: begin
        if (tempFlags.atShut)  shutNext = ST_HOT;
        else if (restartReq)   shutNext = ST_RUN;
      end
      default:   shutNext = ST_HOT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shutState <= ST_RUN;
    else       shutState <= shutNext;
  end

  always_comb begin
    ctrl.selClip   = (modeSel == MODE_CLIP) || (modeSel == MODE_BOTH);
    ctrl.selWarn   = (modeSel == MODE_WARN) || (modeSel == MODE_BOTH);
    ctrl.selTweet  = (modeSel == MODE_TWEET);
    ctrl.clipFlush = (shutState != ST_RUN);
  end

  assign outHiZ = (shutState != ST_RUN);
  assign faultN = (shutState == ST_RUN);

endmodule

// File: rtl/cwr_top.sv
module cwr_top
  import cwr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int PWM_PERIOD = 16,
  parameter int TEMP_W     = 8,
  parameter int WARN_T1    = 100,
  parameter int WARN_T2    = 115,
  parameter int WARN_T3    = 130,
  parameter int SHUT_T     = 150,
  parameter int HYST       = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pwmIn,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [1:0]        pinMode,
  input  logic              tweeterIn,
  input  logic              restartReq,
  output logic              warnPinN,
  output logic [2:0]        thermStatus,
  output logic              outHiZ,
  output logic              faultN
);

  ctrl_strobe_t ctrl;
  temp_flags_t  tempFlags;

  cwr_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .pinMode    (pinMode),
    .restartReq (restartReq),
    .tempFlags  (tempFlags),
    .ctrl       (ctrl),
    .outHiZ     (outHiZ),
    .faultN     (faultN)
  );

  cwr_datapath #(
    .NUM_CH     (NUM_CH),
    .PWM_PERIOD (PWM_PERIOD),
    .TEMP_W     (TEMP_W),
    .WARN_T1    (WARN_T1),
    .WARN_T2    (WARN_T2),
    .WARN_T3    (WARN_T3),
    .SHUT_T     (SHUT_T),
    .HYST       (HYST)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .pwmIn       (pwmIn),
    .tempCode    (tempCode),
    .tweeterIn   (tweeterIn),
    .ctrl        (ctrl),
    .warnPinN    (warnPinN),
    .thermStatus (thermStatus),
    .tempFlags   (tempFlags)
  );

endmodule

// File: rtl/cwr_checker.sv
module cwr_checker #(
  parameter int NUM_CH  = 4,
  parameter int TEMP_W  = 8,
  parameter int WARN_T1 = 100,
  parameter int WARN_T3 = 130,
  parameter int SHUT_T  = 150,
  parameter int HYST    = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] pwmIn,
  input logic [TEMP_W-1:0] tempCode,
  input logic [1:0]        pinMode,
  input logic              tweeterIn,
  input logic              restartReq,
  input logic              warnPinN,
  input logic [2:0]        thermStatus,
  input logic              outHiZ,
  input logic              faultN
);

  localparam logic [TEMP_W:0] T1_EXT   = (TEMP_W+1)'(WARN_T1);
  localparam logic [TEMP_W:0] HYST_EXT = (TEMP_W+1)'(HYST);

  p_set_lvl1_r5: assert property (@(posedge clk) disable iff (!rstN)
    tempCode >= TEMP_W'(WARN_T1) |=> thermStatus[0]);

  p_hold_lvl1_r5: assert property (@(posedge clk) disable iff (!rstN)
    (thermStatus[0] && ({1'b0, tempCode} + HYST_EXT >= T1_EXT)) |=> thermStatus[0]);

  p_set_all_r5: assert property (@(posedge clk) disable iff (!rstN)
    tempCode >= TEMP_W'(WARN_T3) |=> thermStatus == 3'b111);

  p_enter_shut_r6: assert property (@(posedge clk) disable iff (!rstN)
    tempCode >= TEMP_W'(SHUT_T) |=> (outHiZ && !faultN));

  p_need_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outHiZ && !restartReq) |=> outHiZ);

  p_clip_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwmIn) == '0 && pinMode == 2'b01) |=> warnPinN);

  p_tweet_route_r4: assert property (@(posedge clk) disable iff (!rstN)
    pinMode == 2'b11 |=> (warnPinN == !$past(tweeterIn)));

  p_no_clip_hiz_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outHiZ) && pinMode == 2'b01) |=> warnPinN);

endmodule

bind cwr_top cwr_checker #(
  .NUM_CH  (NUM_CH),
  .TEMP_W  (TEMP_W),
  .WARN_T1 (WARN_T1),
  .WARN_T3 (WARN_T3),
  .SHUT_T  (SHUT_T),
  .HYST    (HYST)
) u_chk (.*);

// File: tb/cwr_top_bench.sv
module cwr_top_bench;

  localparam int PERIOD = 16;
  localparam int CLIPN  = PERIOD + 1;
  localparam int TH1 = 100, TH2 = 115, TH3 = 130, SHUT = 150, HYST = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pwmIn = '0;
  logic [7:0] tempCode = 8'd20;
  logic [1:0] pinMode = 2'b00;
  logic       tweeterIn = 1'b0;
  logic       restartReq = 1'b0;
  logic       warnPinN;
  logic [2:0] thermStatus;
  logic       outHiZ;
  logic       faultN;

  int total = 0;
  int bad = 0;

  // reference state
  int   mCnt [4];
  bit   mLvl [3];
  int   mSt;
  bit   mPin;

  always #10 clk = ~clk;

  cwr_top u_cwr_top (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .tempCode(tempCode),
    .pinMode(pinMode), .tweeterIn(tweeterIn), .restartReq(restartReq),
    .warnPinN(warnPinN), .thermStatus(thermStatus), .outHiZ(outHiZ),
    .faultN(faultN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit levelNext(input bit cur, input int t, input int th);
    if (t >= th) return 1'b1;
    if (t + HYST < th) return 1'b0;
    return cur;
  endfunction

  function automatic bit pinNext(input int mode, input bit clipAny, input bit l1, input bit tw);
    bit act;
    case (mode)
      0: act = l1;
      1: act = clipAny;
      2: act = clipAny | l1;
      default: act = tw;
    endcase
    return !act;
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 4; c++) mCnt[c] = 0;
    for (int i = 0; i < 3; i++) mLvl[i] = 1'b0;
    mSt = 0;
    mPin = 1'b1;
  endtask

  // advance one clock with the currently driven inputs, then compare
  task automatic step();
    bit clipAny = 1'b0;
    int t = int'(tempCode);
    int ns = mSt;
    int ths [3] = '{TH1, TH2, TH3};
    for (int c = 0; c < 4; c++) if (mCnt[c] == CLIPN) clipAny = 1'b1;
    mPin = pinNext(int'(pinMode), clipAny, mLvl[0], tweeterIn);
    for (int c = 0; c < 4; c++) begin
      if (mSt != 0 || !pwmIn[c]) mCnt[c] = 0;
      else if (mCnt[c] != CLIPN) mCnt[c]++;
    end
    for (int i = 0; i < 3; i++) mLvl[i] = levelNext(mLvl[i], t, ths[i]);
    case (mSt)
      0: if (t >= SHUT) ns = 1;
      1: if (t + HYST < SHUT) ns = 2;
      default: if (t >= SHUT) ns = 1; else if (restartReq) ns = 0;
    endcase
    mSt = ns;
    @(posedge clk);
    @(negedge clk);
    check(warnPinN == mPin, "R3 R4 pin", warnPinN, mPin);
    check(thermStatus == {mLvl[2], mLvl[1], mLvl[0]}, "R5 R9 status",
          thermStatus, {mLvl[2], mLvl[1], mLvl[0]});
    check(outHiZ == (mSt != 0), "R6 R7 hiz", outHiZ, mSt != 0);
    check(faultN == (mSt == 0), "R6 fault", faultN, mSt == 0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    modelReset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(warnPinN == 1'b1, "R1 pin", warnPinN, 1);
    check(thermStatus == 3'b000, "R1 status", thermStatus, 0);
    check(outHiZ == 1'b0, "R1 hiz", outHiZ, 0);
    check(faultN == 1'b1, "R1 fault", faultN, 1);
    rstN = 1'b1;
    step();

    // R2 boundary: 17 high samples needed, pin reflects it one edge later
    pinMode = 2'b01;
    pwmIn = 4'b0100;
    repeat (17) step();
    check(warnPinN == 1'b1, "R2 not yet clipped", warnPinN, 1);
    step();
    check(warnPinN == 1'b0, "R2 R3 clip seen", warnPinN, 0);
    pwmIn = 4'b0000;
    step();
    check(warnPinN == 1'b0, "R3 pin registered", warnPinN, 0);
    step();
    check(warnPinN == 1'b1, "R2 clip cleared", warnPinN, 1);

    // R4 mode 00 ignores clip; warning level 1 drives pin
    pwmIn = 4'b1111;
    pinMode = 2'b00;
    repeat (20) step();
    check(warnPinN == 1'b1, "R4 clip ignored in warn mode", warnPinN, 1);
    tempCode = 8'd100;
    step(); step();
    check(warnPinN == 1'b0, "R4 warn level1", warnPinN, 0);
    tempCode = 8'd90;
    repeat (3) step();
    check(thermStatus[0] == 1'b1, "R5 hold at threshold-10", thermStatus[0], 1);
    tempCode = 8'd89;
    step();
    check(thermStatus[0] == 1'b0, "R5 clear below threshold-10", thermStatus[0], 0);

    // R6 R7 R8 R9 shutdown with clipping channels in clip mode
    pinMode = 2'b01;
    pwmIn = 4'b1111;
    tempCode = 8'd150;
    step();
    check(outHiZ == 1'b1, "R6 enter shutdown", outHiZ, 1);
    repeat (25) step();
    check(warnPinN == 1'b1, "R8 no clip while off", warnPinN, 1);
    check(thermStatus == 3'b111, "R9 status during shutdown", thermStatus, 7);
    restartReq = 1'b1;
    tempCode = 8'd140;
    repeat (3) step();
    check(outHiZ == 1'b1, "R7 restart while hot ignored", outHiZ, 1);
    restartReq = 1'b0;
    tempCode = 8'd139;
    repeat (3) step();
    check(outHiZ == 1'b1, "R7 cooled still off", outHiZ, 1);
    restartReq = 1'b1;
    step();
    restartReq = 1'b0;
    check(outHiZ == 1'b0, "R7 restart resumes", outHiZ, 0);
    pinMode = 2'b11;
    tweeterIn = 1'b1;
    step(); step();
    check(warnPinN == 1'b0, "R4 tweeter routed", warnPinN, 0);

    // random phase
    tempCode = 8'd60;
    for (int n = 0; n < 4000; n++) begin
      int d;
      if ($urandom_range(0, 99) == 0) tempCode = 8'($urandom_range(0, 200));
      else begin
        d = int'(tempCode) + int'($urandom_range(0, 8)) - 4;
        if (d < 0) d = 0;
        if (d > 200) d = 200;
        tempCode = 8'(d);
      end
      for (int c = 0; c < 4; c++)
        if ($urandom_range(0, 23) == 0) pwmIn[c] = ~pwmIn[c];
        else if (!pwmIn[c] && $urandom_range(0, 3) == 0) pwmIn[c] = 1'b1;
      if ($urandom_range(0, 63) == 0) pinMode = 2'($urandom_range(0, 3));
      tweeterIn = ($urandom_range(0, 7) == 0) ? ~tweeterIn : tweeterIn;
      restartReq = ($urandom_range(0, 29) == 0);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule